// File: doc/BRIEF.md
# Virtual-Channel Input Port Dispatcher

This block is the receive side of one switch port. Fixed-length packets arrive on a single 32-bit valid/ready stream. Each packet names its virtual channel in the first word and is written whole into a free packet-sized buffer that belongs to that channel. A packet becomes eligible to leave only once its last word is stored, so the block works as store-and-forward.

Stored packets leave through a parameterised number of connection points toward the switch matrix. The channel index is its priority, and channel 0 is the most urgent. At most one packet starts per cycle. It is the oldest packet of the most urgent channel that holds a complete packet, and it goes to the lowest-numbered connection point that is idle and whose grant input is high. Any buffer can leave through any point. Once a packet starts on a point, all of its words go out on that point without interruption.

Back-pressure works as follows. On the ingress stream, `in_ready` is high for every word after the first. While the port is idle, `in_ready` follows the channel of the first word offered: it stays low, and the word waits, until that channel has a free buffer. On each connection point, a word moves on a cycle where valid and ready are both high. While ready is low, the data, channel and last flag are held.

Top module: `vc_input_dispatch`

## Requirements
- R1: A packet is `WORDS` (16) words of `DW` (32) bits. Bits [VCW-1:0] of word 0 carry the virtual channel number. Each packet is delivered on a connection point word for word, with the channel on `cp_vc`.
- R2: While idle, `in_ready` is high for an offered first word only if that word's channel has a free buffer, and it stays low until one is free. A channel number of `NUM_VC` or more never gets a buffer. Within a packet, `in_ready` is high.
- R3: A buffer is freed on the cycle its last word is handshaken out, and a stalled packet is then accepted into it.
- R4: Among channels holding complete packets, the lowest-numbered channel is dispatched first. With a single granted point, packets therefore leave in channel order.
- R5: Within one channel, packets start leaving in their arrival order.
- R6: A packet starts on a point only if that point is idle and its `cp_grant` bit is high. The lowest-numbered such point is used, and at most one packet starts per cycle.
- R7: A started packet is sent to completion on its point. A more urgent arrival does not interrupt it, and `cp_data`/`cp_vc` stay stable while ready is low.
- R8: `cp_last` is high only on the final word of a packet, and the point's `cp_valid` is low in the cycle after that word's handshake.
- R9: With two or more points, packets from different channels are sent at the same time on different points, and never from the same buffer.
- R10: After reset, no point is valid and every buffer is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Ingress word valid |
| in_ready | output | 1 | Ingress word accepted when high with valid |
| in_data | input | DW | Ingress word; word 0 carries the channel in its low bits |
| cp_grant | input | NUM_CP | Per-point permission to start a new packet |
| cp_valid | output | NUM_CP | Per-point word valid |
| cp_ready | input | NUM_CP | Per-point word accepted |
| cp_data | output | NUM_CP*DW | Per-point word, point p in bits [p*DW +: DW] |
| cp_vc | output | NUM_CP*VCW | Channel of the packet on each point |
| cp_last | output | NUM_CP | Final word of the packet on each point |

## Verification
Priority order is hard to observe from the ports, because a packet normally leaves as soon as it lands. The bench therefore holds every grant low while it loads several channels, checks that nothing moves, and then opens a single point so that the order of departure shows the priority. The buffer-full stall is reached the same way: a channel is filled while grants are low, and its next first word is then held until a departure frees a buffer. A long run with random per-point ready then mixes channels across both points, so that buffers are reused and packets of one channel leave on different points.

// File: rtl/vcd_pkg.sv
package vcd_pkg;

  // index of the lowest set bit of an eight-bit vector (0 when empty)
  function automatic logic [2:0] first_set8(input logic [7:0] v);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 7; i >= 0; i--) begin
      if (v[i]) r = 3'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/vcd_ingress.sv
module vcd_ingress
  import vcd_pkg::*;
#(
  parameter int NUM_VC = 4,
  parameter int BPV    = 2,
  parameter int WORDS  = 16,
  localparam int NUM_BUF = NUM_VC * BPV,
  localparam int BW  = $clog2(NUM_BUF),
  localparam int CW  = $clog2(WORDS),
  localparam int VCW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int LW  = (BPV > 1) ? $clog2(BPV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [VCW-1:0]     head_vc,
  input  logic [NUM_BUF-1:0] buf_alloc,
  output logic               in_ready,
  output logic               wr_en,
  output logic [BW-1:0]      wr_buf,
  output logic [CW-1:0]      wr_word,
  output logic               set_en,
  output logic               push_en,
  output logic [VCW-1:0]     push_vc,
  output logic [LW-1:0]      push_local
);

  logic           recv;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  cur_buf;
  logic [VCW-1:0] cur_vc;
  logic [LW-1:0]  cur_local;
  logic [7:0]     free_vec;
  logic [LW-1:0]  free_local;
  logic           have_free;
  logic           fire;

  always_comb begin
    free_vec = '0;
    if (int'(head_vc) < NUM_VC) begin
      for (int k = 0; k < BPV; k++) begin
        free_vec[k] = !buf_alloc[int'(head_vc) * BPV + k];
      end
    end
    free_local = LW'(first_set8(free_vec));
    have_free  = |free_vec;
  end

  assign in_ready   = recv || have_free;
  assign fire       = in_valid && in_ready;
  assign wr_en      = fire;
  assign wr_buf     = recv ? cur_buf : BW'(int'(head_vc) * BPV + int'(free_local));
  assign wr_word    = recv ? cnt : '0;
  assign set_en     = fire && !recv;
  assign push_en    = fire && recv && (cnt == CW'(WORDS - 1));
  assign push_vc    = cur_vc;
  assign push_local = cur_local;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      recv      <= 1'b0;
      cnt       <= '0;
      cur_buf   <= '0;
      cur_vc    <= '0;
      cur_local <= '0;
    end else if (fire) begin
      if (!recv) begin
        recv      <= 1'b1;
        cnt       <= CW'(1);
        cur_buf   <= wr_buf;
        cur_vc    <= head_vc;
        cur_local <= free_local;
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(WORDS - 1)) recv <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vcd_order_fifo.sv
module vcd_order_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 1,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [NW-1:0] fill;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head  = slot[rd_ptr];
  assign empty = (fill == '0);

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      if (push && !pop)      fill <= fill + 1'b1;
      else if (pop && !push) fill <= fill - 1'b1;
    end
  end

endmodule

// File: rtl/vcd_dispatch.sv
module vcd_dispatch
  import vcd_pkg::*;
#(
  parameter int NUM_VC = 4,
  parameter int NUM_CP = 2,
  localparam int VCW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int PTW = (NUM_CP > 1) ? $clog2(NUM_CP) : 1
) (
  input  logic [NUM_VC-1:0] fifo_empty,
  input  logic [NUM_CP-1:0] pt_busy,
  input  logic [NUM_CP-1:0] cp_grant,
  output logic              start_en,
  output logic [VCW-1:0]    start_vc,
  output logic [PTW-1:0]    start_pt
);

  logic [7:0] waiting;
  logic [7:0] avail;

  always_comb begin
    waiting = '0;
    avail   = '0;
    waiting[NUM_VC-1:0] = ~fifo_empty;
    avail[NUM_CP-1:0]   = ~pt_busy & cp_grant;
  end

  assign start_en = (|waiting) && (|avail);
  assign start_vc = VCW'(first_set8(waiting));
  assign start_pt = PTW'(first_set8(avail));

endmodule

// File: rtl/vc_input_dispatch.sv
module vc_input_dispatch #(
  parameter int NUM_VC = 4,
  parameter int BPV    = 2,
  parameter int NUM_CP = 2,
  parameter int WORDS  = 16,
  parameter int DW     = 32,
  localparam int NUM_BUF = NUM_VC * BPV,
  localparam int BW  = $clog2(NUM_BUF),
  localparam int CW  = $clog2(WORDS),
  localparam int VCW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int LW  = (BPV > 1) ? $clog2(BPV) : 1,
  localparam int PTW = (NUM_CP > 1) ? $clog2(NUM_CP) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DW-1:0]         in_data,
  input  logic [NUM_CP-1:0]     cp_grant,
  output logic [NUM_CP-1:0]     cp_valid,
  input  logic [NUM_CP-1:0]     cp_ready,
  output logic [NUM_CP*DW-1:0]  cp_data,
  output logic [NUM_CP*VCW-1:0] cp_vc,
  output logic [NUM_CP-1:0]     cp_last
);

  logic [DW-1:0] mem [NUM_BUF][WORDS];

  logic [NUM_BUF-1:0] buf_alloc;
  logic               wr_en, set_en, push_en;
  logic [BW-1:0]      wr_buf;
  logic [CW-1:0]      wr_word;
  logic [VCW-1:0]     push_vc;
  logic [LW-1:0]      push_local;

  logic [NUM_VC-1:0]  fifo_empty;
  logic [LW-1:0]      head_loc [NUM_VC];
  logic               start_en;
  logic [VCW-1:0]     start_vc;
  logic [PTW-1:0]     start_pt;
  logic [BW-1:0]      start_buf;

  logic [NUM_CP-1:0]    pt_busy;
  logic [NUM_CP-1:0]    clr_en;
  logic [BW-1:0]        clr_idx [NUM_CP];
  logic [NUM_CP*BW-1:0] pt_buf_flat;

  vcd_ingress #(.NUM_VC(NUM_VC), .BPV(BPV), .WORDS(WORDS)) u_ingress (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .head_vc(in_data[VCW-1:0]),
    .buf_alloc(buf_alloc), .in_ready(in_ready), .wr_en(wr_en), .wr_buf(wr_buf),
    .wr_word(wr_word), .set_en(set_en), .push_en(push_en), .push_vc(push_vc),
    .push_local(push_local)
  );

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_buf][wr_word] <= in_data;
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    vcd_order_fifo #(.DEPTH(BPV), .W(LW)) u_order (
      .clk(clk), .rst_n(rst_n),
      .push(push_en && (push_vc == VCW'(v))), .din(push_local),
      .pop(start_en && (start_vc == VCW'(v))),
      .head(head_loc[v]), .empty(fifo_empty[v])
    );
  end

  vcd_dispatch #(.NUM_VC(NUM_VC), .NUM_CP(NUM_CP)) u_dispatch (
    .fifo_empty(fifo_empty), .pt_busy(pt_busy), .cp_grant(cp_grant),
    .start_en(start_en), .start_vc(start_vc), .start_pt(start_pt)
  );

  assign start_buf = BW'(int'(start_vc) * BPV + int'(head_loc[start_vc]));

  for (genvar p = 0; p < NUM_CP; p++) begin : g_pt
    logic           busy;
    logic [BW-1:0]  pbuf;
    logic [VCW-1:0] pvc;
    logic [CW-1:0]  cnt;
    logic           go, at_end;

    assign go     = start_en && (start_pt == PTW'(p));
    assign at_end = (cnt == CW'(WORDS - 1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy <= 1'b0;
        pbuf <= '0;
        pvc  <= '0;
        cnt  <= '0;
      end else if (go) begin
        busy <= 1'b1;
        pbuf <= start_buf;
        pvc  <= start_vc;
        cnt  <= '0;
      end else if (busy && cp_ready[p]) begin
        cnt <= cnt + 1'b1;
        if (at_end) busy <= 1'b0;
      end
    end

    assign pt_busy[p]                = busy;
    assign clr_en[p]                 = busy && cp_ready[p] && at_end;
    assign clr_idx[p]                = pbuf;
    assign pt_buf_flat[p*BW +: BW]   = pbuf;
    assign cp_valid[p]               = busy;
    assign cp_last[p]                = busy && at_end;
    assign cp_vc[p*VCW +: VCW]       = pvc;
    assign cp_data[p*DW +: DW]       = busy ? mem[pbuf][cnt] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_alloc <= '0;
    end else begin
      for (int b = 0; b < NUM_BUF; b++) begin
        if (set_en && (wr_buf == BW'(b))) buf_alloc[b] <= 1'b1;
        for (int q = 0; q < NUM_CP; q++) begin
          if (clr_en[q] && (clr_idx[q] == BW'(b))) buf_alloc[b] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/vcd_checker.sv
module vcd_checker #(
  parameter int NUM_CP = 2,
  parameter int DW     = 32,
  parameter int VCW    = 2,
  parameter int BW     = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_CP-1:0]     cp_valid,
  input logic [NUM_CP-1:0]     cp_ready,
  input logic [NUM_CP-1:0]     cp_last,
  input logic [NUM_CP-1:0]     cp_grant,
  input logic [NUM_CP*DW-1:0]  cp_data,
  input logic [NUM_CP*VCW-1:0] cp_vc,
  input logic [NUM_CP*BW-1:0]  pt_buf_flat
);

  for (genvar p = 0; p < NUM_CP; p++) begin : g_p
    // R7: a stalled word and its channel are held until taken
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_valid[p] && !cp_ready[p]) |=>
        (cp_valid[p] && $stable(cp_data[p*DW +: DW]) && $stable(cp_vc[p*VCW +: VCW])));

    // R6: a packet only begins on a point whose grant was high
    p_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cp_valid[p]) |-> $past(cp_grant[p]));

    // R8: the point goes idle right after the final word
    p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_valid[p] && cp_ready[p] && cp_last[p]) |=> !cp_valid[p]);

    // R8: valid only drops after a taken final word
    p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cp_valid[p]) |-> $past(cp_last[p] && cp_ready[p]));
  end

  for (genvar i = 0; i < NUM_CP; i++) begin : g_a
    for (genvar j = i + 1; j < NUM_CP; j++) begin : g_b
      // R9: two active points never read the same buffer
      p_distinct_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid[i] && cp_valid[j]) |->
          (pt_buf_flat[i*BW +: BW] != pt_buf_flat[j*BW +: BW]));
    end
  end

endmodule

bind vc_input_dispatch vcd_checker #(.NUM_CP(NUM_CP), .DW(DW), .VCW(VCW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cp_valid(cp_valid), .cp_ready(cp_ready),
  .cp_last(cp_last), .cp_grant(cp_grant), .cp_data(cp_data), .cp_vc(cp_vc),
  .pt_buf_flat(pt_buf_flat)
);

// File: tb/tb_vc_input_dispatch.sv
`timescale 1ns/100ps
module tb_vc_input_dispatch;
  localparam int NVC = 4;
  localparam int NCP = 2;
  localparam int W   = 16;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [NCP-1:0] cp_grant = '0;
  logic [NCP-1:0] cp_ready = '1;
  wire in_ready;
  wire [NCP-1:0] cp_valid, cp_last;
  wire [NCP*DW-1:0] cp_data;
  wire [NCP*2-1:0] cp_vc;

  always #2.5 clk = ~clk;

  vc_input_dispatch #(.NUM_VC(NVC), .BPV(2), .NUM_CP(NCP), .WORDS(W), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cp_grant(cp_grant), .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_data(cp_data),
    .cp_vc(cp_vc), .cp_last(cp_last)
  );

  int checks = 0;
  int errors = 0;
  int exp_q [NVC][$];
  int log_vc[$];
  int log_pt[$];
  int comp_cnt = 0;
  bit ready_rand = 1'b0;
  bit finished = 1'b0;
  logic [7:0] lfsr = 8'h5B;

  function automatic logic [31:0] wordv(int vc, int id, int i);
    if (i == 0) return 32'((id << 8) | vc);
    return 32'((id << 16) | (i << 8) | 'h5A);
  endfunction

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  // scoreboard monitor
  int m_idx [NCP];
  int m_id  [NCP];
  int m_vc  [NCP];
  initial for (int p = 0; p < NCP; p++) m_idx[p] = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NCP; p++) begin
        if (cp_valid[p] && cp_ready[p]) begin
          logic [31:0] d;
          int v;
          d = cp_data[p*DW +: DW];
          v = int'(cp_vc[p*2 +: 2]);
          if (m_idx[p] == 0) begin
            m_vc[p] = v;
            m_id[p] = int'(d >> 8);
            chk(int'(d[1:0]) == v, "R1", "channel field vs cp_vc", int'(d[1:0]), v);
            if (exp_q[v].size() == 0) begin
              chk(1'b0, "R5", "unexpected packet id", m_id[p], -1);
            end else begin
              int e;
              e = exp_q[v].pop_front();
              chk(m_id[p] == e, "R5", "packet order in channel", m_id[p], e);
            end
            log_vc.push_back(v);
            log_pt.push_back(p);
          end else begin
            chk(d == wordv(m_vc[p], m_id[p], m_idx[p]), "R1", "payload word",
                int'(d), int'(wordv(m_vc[p], m_id[p], m_idx[p])));
            chk(v == m_vc[p], "R7", "channel changed mid-packet", v, m_vc[p]);
          end
          chk(cp_last[p] == (m_idx[p] == W - 1), "R8", "last flag position",
              int'(cp_last[p]), int'(m_idx[p] == W - 1));
          m_idx[p]++;
          if (m_idx[p] == W) begin
            m_idx[p] = 0;
            comp_cnt++;
          end
        end
      end
    end
  end

  // ready pattern on the connection points
  always @(posedge clk) begin
    #1;
    if (ready_rand) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cp_ready = lfsr[1:0];
    end else begin
      cp_ready = '1;
    end
  end

  task automatic send_pkt(int vc, int id);
    exp_q[vc].push_back(id);
    for (int i = 0; i < W; i++) begin
      in_valid = 1'b1;
      in_data  = wordv(vc, id, i);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (t < 3000 && ((exp_q[0].size() + exp_q[1].size() + exp_q[2].size() +
                         exp_q[3].size()) != 0 || (|cp_valid))) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
    chk((exp_q[0].size() + exp_q[1].size() + exp_q[2].size() + exp_q[3].size()) == 0,
        "R5", "packets left undelivered",
        exp_q[0].size() + exp_q[1].size() + exp_q[2].size() + exp_q[3].size(), 0);
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok;
    int c0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(cp_valid == '0, "R10", "valid after reset", int'(cp_valid), 0);
    chk(in_ready == 1'b1, "R10", "ready for channel 0 after reset", int'(in_ready), 1);
    @(posedge clk);
    #1;

    // priority: load with grants closed, then open point 0 only
    cp_grant = '0;
    send_pkt(3, 1);
    send_pkt(2, 2);
    send_pkt(1, 3);
    send_pkt(1, 4);
    send_pkt(0, 5);
    ok = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (cp_valid != '0) ok = 1'b0;
    end
    chk(ok, "R6", "no start without grant", int'(ok), 1);
    log_vc.delete();
    log_pt.delete();
    @(posedge clk);
    #1;
    cp_grant = 2'b01;
    drain();
    chk(log_vc.size() == 5, "R4", "packets out", log_vc.size(), 5);
    if (log_vc.size() == 5) begin
      chk(log_vc[0] == 0 && log_vc[1] == 1 && log_vc[2] == 1 && log_vc[3] == 2 && log_vc[4] == 3,
          "R4", "priority order head channel", log_vc[0], 0);
      chk(log_pt[0] == 0 && log_pt[4] == 0, "R6", "only granted point used", log_pt[4], 0);
    end

    // stall on a full channel, then release
    cp_grant = '0;
    send_pkt(2, 10);
    send_pkt(2, 11);
    in_valid = 1'b1;
    in_data  = wordv(2, 12, 0);
    ok = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (in_ready) ok = 1'b0;
    end
    chk(ok, "R2", "ready low on full channel", int'(!ok), 0);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    c0 = comp_cnt;
    cp_grant = 2'b01;
    send_pkt(2, 12);
    chk(comp_cnt - c0 >= 1, "R3", "stalled packet taken only after a buffer freed",
        comp_cnt - c0, 1);
    drain();

    // non-preemption: urgent packet arrives while a slow one is sent
    log_vc.delete();
    log_pt.delete();
    cp_grant = 2'b01;
    send_pkt(3, 20);
    send_pkt(0, 21);
    drain();
    chk(log_vc.size() == 2 && log_vc[0] == 3, "R7", "started packet finishes first",
        log_vc.size() > 0 ? log_vc[0] : -1, 3);

    // parallel points and lowest free point
    cp_grant = '0;
    log_vc.delete();
    log_pt.delete();
    send_pkt(1, 30);
    send_pkt(2, 31);
    cp_grant = 2'b11;
    ok = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (&cp_valid) ok = 1'b1;
    end
    chk(ok, "R9", "both points active together", int'(ok), 1);
    @(posedge clk);
    #1;
    drain();
    chk(log_vc.size() == 2 && log_vc[0] == 1 && log_pt[0] == 0, "R6",
        "urgent packet on lowest point", log_pt.size() > 0 ? log_pt[0] : -1, 0);
    chk(log_vc.size() == 2 && log_vc[1] == 2 && log_pt[1] == 1, "R9",
        "second packet on next point", log_pt.size() > 1 ? log_pt[1] : -1, 1);

    // mixed stream with random ready, buffers reused many times
    ready_rand = 1'b1;
    c0 = comp_cnt;
    for (int k = 0; k < 24; k++) send_pkt((k * 5 + k / 3) % 4, 100 + k);
    drain();
    ready_rand = 1'b0;
    chk(comp_cnt - c0 == 24, "R3", "stream packets completed", comp_cnt - c0, 24);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule